// File: doc/BRIEF.md
# Multi-Cycle Processor Datapath

This block is the datapath of a 32-bit processor that runs each instruction over several clock cycles. A single adder/logic unit does all the arithmetic in turn: the next sequential PC, the load/store effective address, the branch target and the result of an ALU instruction. Instructions and data come through one shared memory port. The address on that port is either the PC (instruction fetch) or the held result (data access).

Five holding registers carry state from one phase to the next: the instruction register, the memory data register, the two operand registers and the result register. Each has its own load enable. An external sequencer drives every enable and every mux select, one phase at a time. It reads back the opcode, the function field and an operand-equality flag, and uses them to pick the phases. The 32-entry register file has two read ports, which read combinationally from the rs and rt fields of the held instruction, and one write port.

Top module: `mcdp_datapath`

## Requirements
- R1: The PC, instruction register, memory data register, operand registers A and B, and the result register each take a new value at a clock edge only when their own enable is high. Otherwise they hold, whatever the selects and the memory data do.
- R2: `mem_addr` equals the PC when `addr_sel` is 0 and the result register when `addr_sel` is 1.
- R3: `mem_wdata` always shows operand register B.
- R4: Instruction fields are decoded as follows: opcode in bits 31:26, rs in 25:21, rt in 20:16, rd in 15:11, function field in 5:0, and a 16-bit immediate in 15:0. The immediate is sign-extended to 32 bits. `opcode` and `funct` output the fields of the instruction register.
- R5: With `pc_sel` = 2, the PC loads {PC[31:28], IR[25:0], 2'b00}.
- R6: ALU input A is the PC when `opa_sel` is 0 and register A when it is 1. ALU input B is chosen by `opb_sel` as follows: 0 gives B, 1 gives the constant 4, 2 gives the sign-extended immediate, and 3 gives the sign-extended immediate shifted left by two. `alu_op` codes: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 signed less-than, 6 NOR, 7 unsigned less-than. The less-than codes give 1 or 0.
- R7: A register-file write goes to rt when `dst_sel` is 0 and to rd when it is 1. The written value is the result register when `wb_sel` is 0 and the memory data register when it is 1.
- R8: The PC source is chosen by `pc_sel`: 0 (and 3) takes the ALU output, 1 takes the result register, 2 takes the jump concatenation.
- R9: Register 0 always reads as zero. Writes to it are ignored.
- R10: `ops_equal` is high exactly when operand registers A and B hold equal values.
- R11: While `rst_n` is low, the PC is set to `RESET_PC` and every holding register and register-file entry is set to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_we | input | 1 | PC load enable |
| ir_we | input | 1 | Instruction register load enable |
| mdr_we | input | 1 | Memory data register load enable |
| a_we | input | 1 | Operand A load enable |
| b_we | input | 1 | Operand B load enable |
| res_we | input | 1 | Result register load enable |
| rf_we | input | 1 | Register-file write enable |
| addr_sel | input | 1 | Memory address source: 0 PC, 1 result |
| opa_sel | input | 1 | ALU input A source: 0 PC, 1 register A |
| opb_sel | input | 2 | ALU input B source: B, 4, immediate, immediate<<2 |
| alu_op | input | 3 | ALU operation code |
| dst_sel | input | 1 | Write address: 0 rt, 1 rd |
| wb_sel | input | 1 | Write data: 0 result, 1 memory data register |
| pc_sel | input | 2 | PC source: ALU, result, jump |
| mem_rdata | input | 32 | Read data from the shared memory |
| mem_addr | output | 32 | Byte address to the shared memory |
| mem_wdata | output | 32 | Write data to the shared memory |
| opcode | output | 6 | Opcode field of the instruction register |
| funct | output | 6 | Function field of the instruction register |
| ops_equal | output | 1 | Operand A equals operand B |
| pc | output | 32 | Current program counter |

## Verification
The hardest condition to reach from the ports is a long idle stretch in the middle of a program. During it every enable is low, while the selects, the ALU code and the memory contents keep changing. A leaky enable on A, B, the result register or the register file shows up only in later instructions, not in that cycle. The bench therefore sits in such a window with random selects and garbage at the fetch address, then continues its program. Every later branch decision, store and final register dump is checked against a reference model that assumed nothing changed. Writes to register 0, sign-negative immediates and backward branch offsets are placed as directed instructions before the random stream.

// File: rtl/mcdp_pkg.sv
package mcdp_pkg;

  localparam int XLEN     = 32;
  localparam int RIDX_W   = 5;
  localparam int NREGS    = 1 << RIDX_W;
  localparam int IMM_W    = 16;
  localparam int JIDX_W   = 26;
  localparam int OPC_W    = 6;

  typedef enum logic [2:0] {
    ALU_ADD  = 3'd0,
    ALU_SUB  = 3'd1,
    ALU_AND  = 3'd2,
    ALU_OR   = 3'd3,
    ALU_XOR  = 3'd4,
    ALU_SLT  = 3'd5,
    ALU_NOR  = 3'd6,
    ALU_SLTU = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    OPB_REG   = 2'd0,
    OPB_FOUR  = 2'd1,
    OPB_IMM   = 2'd2,
    OPB_IMMX4 = 2'd3
  } opb_sel_e;

  typedef enum logic [1:0] {
    PCS_ALU  = 2'd0,
    PCS_RES  = 2'd1,
    PCS_JUMP = 2'd2,
    PCS_ALT  = 2'd3
  } pc_sel_e;

  typedef struct packed {
    logic [OPC_W-1:0]  opcode;
    logic [RIDX_W-1:0] rs;
    logic [RIDX_W-1:0] rt;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] shamt;
    logic [OPC_W-1:0]  funct;
  } instr_fields_t;

  function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] imm);
    return {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] jump_target(input logic [XLEN-1:0] cur_pc,
                                                  input logic [XLEN-1:0] instr);
    return {cur_pc[XLEN-1:JIDX_W+2], instr[JIDX_W-1:0], 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input logic [2:0] op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [XLEN-1:0] y;
    case (alu_op_e'(op))
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_AND:  y = a & b;
      ALU_OR:   y = a | b;
      ALU_XOR:  y = a ^ b;
      ALU_SLT:  y = ($signed(a) < $signed(b)) ? {{(XLEN-1){1'b0}}, 1'b1} : '0;
      ALU_NOR:  y = ~(a | b);
      ALU_SLTU: y = (a < b) ? {{(XLEN-1){1'b0}}, 1'b1} : '0;
      default:  y = '0;
    endcase
    return y;
  endfunction

endpackage

// File: rtl/mcdp_enreg.sv
module mcdp_enreg #(
  parameter int          W       = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= RST_VAL;
    else if (en) q <= d;
  end

endmodule

// File: rtl/mcdp_regfile.sv
module mcdp_regfile #(
  parameter int N = 32,
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [$clog2(N)-1:0] ra_a,
  input  logic [$clog2(N)-1:0] ra_b,
  output logic [W-1:0]         rd_a,
  output logic [W-1:0]         rd_b,
  input  logic                 we,
  input  logic [$clog2(N)-1:0] wa,
  input  logic [W-1:0]         wd
);

  localparam int AW = $clog2(N);

  logic [W-1:0] regs [N];
  logic         wr_live;

  // a write aimed at entry 0 is dropped
  assign wr_live = we && (wa != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (wr_live) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a = (ra_a == AW'(0)) ? '0 : regs[ra_a];
  assign rd_b = (ra_b == AW'(0)) ? '0 : regs[ra_b];

endmodule

// File: rtl/mcdp_alu.sv
module mcdp_alu
  import mcdp_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  assign y = alu_eval(op, a, b);

endmodule

// File: rtl/mcdp_datapath.sv
module mcdp_datapath
  import mcdp_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pc_we,
  input  logic            ir_we,
  input  logic            mdr_we,
  input  logic            a_we,
  input  logic            b_we,
  input  logic            res_we,
  input  logic            rf_we,
  input  logic            addr_sel,
  input  logic            opa_sel,
  input  logic [1:0]      opb_sel,
  input  logic [2:0]      alu_op,
  input  logic            dst_sel,
  input  logic            wb_sel,
  input  logic [1:0]      pc_sel,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic [OPC_W-1:0] opcode,
  output logic [OPC_W-1:0] funct,
  output logic            ops_equal,
  output logic [XLEN-1:0] pc
);

  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0]   pc_q, pc_next;
  logic [XLEN-1:0]   ir_q, mdr_q, a_q, b_q, res_q;
  logic [XLEN-1:0]   rf_rd_a, rf_rd_b;
  logic [XLEN-1:0]   imm_ext, imm_x4, jump_tgt;
  logic [XLEN-1:0]   alu_a, alu_b, alu_y;
  logic [RIDX_W-1:0] wr_addr;
  logic [XLEN-1:0]   wr_data;
  instr_fields_t     fld;

  assign fld      = instr_fields_t'(ir_q);
  assign imm_ext  = sext_imm(ir_q[IMM_W-1:0]);
  assign imm_x4   = imm_ext << 2;
  assign jump_tgt = jump_target(pc_q, ir_q);

  // program counter
  mcdp_enreg #(.W(XLEN), .RST_VAL(RESET_PC)) u_pc (
    .clk(clk), .rst_n(rst_n), .en(pc_we), .d(pc_next), .q(pc_q)
  );

  // phase-holding registers
  mcdp_enreg #(.W(XLEN)) u_ir  (.clk(clk), .rst_n(rst_n), .en(ir_we),  .d(mem_rdata), .q(ir_q));
  mcdp_enreg #(.W(XLEN)) u_mdr (.clk(clk), .rst_n(rst_n), .en(mdr_we), .d(mem_rdata), .q(mdr_q));
  mcdp_enreg #(.W(XLEN)) u_a   (.clk(clk), .rst_n(rst_n), .en(a_we),   .d(rf_rd_a),   .q(a_q));
  mcdp_enreg #(.W(XLEN)) u_b   (.clk(clk), .rst_n(rst_n), .en(b_we),   .d(rf_rd_b),   .q(b_q));
  mcdp_enreg #(.W(XLEN)) u_res (.clk(clk), .rst_n(rst_n), .en(res_we), .d(alu_y),     .q(res_q));

  // register file
  assign wr_addr = dst_sel ? fld.rd : fld.rt;
  assign wr_data = wb_sel  ? mdr_q  : res_q;

  mcdp_regfile #(.N(NREGS), .W(XLEN)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_a(fld.rs), .ra_b(fld.rt),
    .rd_a(rf_rd_a), .rd_b(rf_rd_b),
    .we(rf_we), .wa(wr_addr), .wd(wr_data)
  );

  // shared ALU operand selection
  assign alu_a = opa_sel ? a_q : pc_q;

  always_comb begin
    case (opb_sel_e'(opb_sel))
      OPB_REG:   alu_b = b_q;
      OPB_FOUR:  alu_b = STEP;
      OPB_IMM:   alu_b = imm_ext;
      OPB_IMMX4: alu_b = imm_x4;
      default:   alu_b = b_q;
    endcase
  end

  mcdp_alu #(.W(XLEN)) u_alu (.op(alu_op), .a(alu_a), .b(alu_b), .y(alu_y));

  // next PC source
  always_comb begin
    case (pc_sel_e'(pc_sel))
      PCS_RES:  pc_next = res_q;
      PCS_JUMP: pc_next = jump_tgt;
      default:  pc_next = alu_y;
    endcase
  end

  // memory port and controller feedback
  assign mem_addr  = addr_sel ? res_q : pc_q;
  assign mem_wdata = b_q;
  assign opcode    = fld.opcode;
  assign funct     = fld.funct;
  assign ops_equal = (a_q == b_q);
  assign pc        = pc_q;

endmodule

// File: rtl/mcdp_datapath_chk.sv
module mcdp_datapath_chk
  import mcdp_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            pc_we,
  input logic            ir_we,
  input logic            mdr_we,
  input logic            a_we,
  input logic            b_we,
  input logic            addr_sel,
  input logic [1:0]      pc_sel,
  input logic [XLEN-1:0] mem_rdata,
  input logic [XLEN-1:0] mem_addr,
  input logic [XLEN-1:0] mem_wdata,
  input logic            ops_equal,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] ir_q,
  input logic [XLEN-1:0] mdr_q,
  input logic [XLEN-1:0] a_q,
  input logic [XLEN-1:0] res_q,
  input logic [XLEN-1:0] rf_rd_a,
  input logic [XLEN-1:0] rf_rd_b
);

  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_we |=> $stable(ir_q)); // R1

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_we |=> $stable(pc)); // R1

  AST_MDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    mdr_we |=> (mdr_q == $past(mem_rdata))); // R1

  AST_ADDR_FROM_RES: assert property (@(posedge clk) disable iff (!rst_n)
    addr_sel |-> (mem_addr == res_q)); // R2

  AST_STORE_FROM_B: assert property (@(posedge clk) disable iff (!rst_n)
    b_we |=> (mem_wdata == $past(rf_rd_b))); // R3

  AST_JUMP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && pc_sel == 2'd2) |=> (pc[1:0] == 2'b00 && pc[31:28] == $past(pc[31:28]))); // R5

  AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (a_we && ir_q[25:21] == 5'd0) |=> (a_q == '0)); // R9

  AST_EQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (a_we && b_we) |=> (ops_equal == $past(rf_rd_a == rf_rd_b))); // R10

endmodule

bind mcdp_datapath mcdp_datapath_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pc_we(pc_we), .ir_we(ir_we), .mdr_we(mdr_we),
  .a_we(a_we), .b_we(b_we), .addr_sel(addr_sel), .pc_sel(pc_sel),
  .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .ops_equal(ops_equal), .pc(pc), .ir_q(ir_q), .mdr_q(mdr_q), .a_q(a_q),
  .res_q(res_q), .rf_rd_a(rf_rd_a), .rf_rd_b(rf_rd_b)
);

// File: tb/mcdp_datapath_tb.sv
`timescale 1ns/1ps
module mcdp_datapath_tb;

  localparam logic [5:0] OP_R = 6'h00, OP_J = 6'h02, OP_BEQ = 6'h04,
                         OP_ADDI = 6'h08, OP_LW = 6'h23, OP_SW = 6'h2B;
  localparam logic [31:0] CODE_LIMIT = 32'h7F0;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic pc_we, ir_we, mdr_we, a_we, b_we, res_we, rf_we;
  logic addr_sel, opa_sel, dst_sel, wb_sel;
  logic [1:0] opb_sel, pc_sel;
  logic [2:0] alu_op;
  logic [31:0] mem_rdata, mem_addr, mem_wdata, pc;
  logic [5:0] opcode, funct;
  logic ops_equal;

  logic [31:0] mem  [1024];
  logic [31:0] mreg [32];
  logic [31:0] mpc;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  assign mem_rdata = mem[mem_addr[11:2]];

  mcdp_datapath u_dut (
    .clk(clk), .rst_n(rst_n), .pc_we(pc_we), .ir_we(ir_we), .mdr_we(mdr_we),
    .a_we(a_we), .b_we(b_we), .res_we(res_we), .rf_we(rf_we),
    .addr_sel(addr_sel), .opa_sel(opa_sel), .opb_sel(opb_sel), .alu_op(alu_op),
    .dst_sel(dst_sel), .wb_sel(wb_sel), .pc_sel(pc_sel), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .opcode(opcode), .funct(funct),
    .ops_equal(ops_equal), .pc(pc)
  );

  function automatic logic [31:0] m_sext(input logic [15:0] i);
    return {{16{i[15]}}, i};
  endfunction

  function automatic logic [31:0] m_alu(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
    case (fn)
      6'h20: return a + b;
      6'h22: return a - b;
      6'h24: return a & b;
      6'h25: return a | b;
      6'h26: return a ^ b;
      6'h27: return ~(a | b);
      6'h2A: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return (a < b) ? 32'd1 : 32'd0;
    endcase
  endfunction

  function automatic logic [2:0] fn_code(input logic [5:0] fn);
    case (fn)
      6'h20: return 3'd0;
      6'h22: return 3'd1;
      6'h24: return 3'd2;
      6'h25: return 3'd3;
      6'h26: return 3'd4;
      6'h27: return 3'd6;
      6'h2A: return 3'd5;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic [5:0] pick_fn(input int k);
    case (k % 8)
      0: return 6'h20; 1: return 6'h22; 2: return 6'h24; 3: return 6'h25;
      4: return 6'h26; 5: return 6'h27; 6: return 6'h2A; default: return 6'h2B;
    endcase
  endfunction

  function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
    return {OP_R, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr_ctl();
    pc_we = 0; ir_we = 0; mdr_we = 0; a_we = 0; b_we = 0; res_we = 0; rf_we = 0;
    addr_sel = 0; opa_sel = 0; opb_sel = 0; alu_op = 0; dst_sel = 0; wb_sel = 0; pc_sel = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic exec(input logic [31:0] ins);
    logic [5:0] op, fn;
    logic [4:0] rs, rt, rd, dest;
    logic [15:0] imm;
    logic [31:0] va, vb, brt, res, val;
    op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    fn = ins[5:0]; imm = ins[15:0];
    va = mreg[rs]; vb = mreg[rt];
    mem[mpc[11:2]] = ins;
    // fetch
    clr_ctl(); ir_we = 1; pc_we = 1; opb_sel = 2'd1;
    #1 chk("R2 fetch address", mem_addr, mpc);
    tick();
    mpc = mpc + 4;
    chk("R4 opcode", {26'd0, opcode}, {26'd0, op});
    chk("R4 funct", {26'd0, funct}, {26'd0, fn});
    chk("R8 pc+4", pc, mpc);
    // decode
    clr_ctl(); a_we = 1; b_we = 1; res_we = 1; opb_sel = 2'd3;
    if (op == OP_J) begin pc_we = 1; pc_sel = 2'd2; end
    tick();
    if (op == OP_J) begin
      mpc = {mpc[31:28], ins[25:0], 2'b00};
      chk("R5 jump target", pc, mpc);
      return;
    end
    brt = mpc + (m_sext(imm) << 2);
    // execute
    clr_ctl();
    if (op == OP_R) begin
      opa_sel = 1; opb_sel = 2'd0; alu_op = fn_code(fn); res_we = 1;
    end else if (op == OP_BEQ) begin
      #1 chk("R10 equality flag", {31'd0, ops_equal}, {31'd0, va == vb});
      if (ops_equal) begin pc_we = 1; pc_sel = 2'd1; end
    end else begin
      opa_sel = 1; opb_sel = 2'd2; res_we = 1;
    end
    tick();
    if (op == OP_BEQ) begin
      if (va == vb) mpc = brt;
      chk("R8 R6 branch pc", pc, mpc);
      return;
    end
    res = (op == OP_R) ? m_alu(fn, va, vb) : va + m_sext(imm);
    // memory
    if (op == OP_LW || op == OP_SW) begin
      clr_ctl(); addr_sel = 1; mdr_we = (op == OP_LW);
      #1 chk("R2 R6 data address", mem_addr, res);
      if (op == OP_SW) begin
        chk("R3 store data", mem_wdata, vb);
        mem[mem_addr[11:2]] = mem_wdata;
      end
      tick();
      if (op == OP_SW) return;
    end
    // write back
    clr_ctl(); rf_we = 1; dst_sel = (op == OP_R); wb_sel = (op == OP_LW);
    if (op == OP_LW) val = mem[res[11:2]];
    else val = res;
    dest = (op == OP_R) ? rd : rt;
    tick();
    if (dest != 5'd0) mreg[dest] = val;
  endtask

  task automatic hold_window();
    logic [31:0] pc_s, res_s;
    logic [5:0] op_s, fn_s;
    logic eq_s;
    clr_ctl(); addr_sel = 1;
    #1;
    pc_s = pc; res_s = mem_addr; op_s = opcode; fn_s = funct; eq_s = ops_equal;
    for (int k = 0; k < 6; k++) begin
      opa_sel = $urandom; opb_sel = $urandom; alu_op = $urandom; pc_sel = $urandom;
      dst_sel = $urandom; wb_sel = $urandom;
      mem[pc[11:2]] = $urandom;
      tick();
      chk("R1 pc held", pc, pc_s);
      chk("R1 ir held", {20'd0, opcode, funct}, {20'd0, op_s, fn_s});
      chk("R1 res held", mem_addr, res_s);
      chk("R1 operands held", {31'd0, ops_equal}, {31'd0, eq_s});
    end
  endtask

  task automatic rand_instr();
    int kind, k;
    logic [4:0] rs, rt, rd;
    logic [15:0] imm;
    logic [31:0] t;
    if (mpc >= CODE_LIMIT) begin
      exec({OP_J, 26'($urandom % 400)});
      return;
    end
    kind = $urandom % 6;
    rs = 5'($urandom % 32); rt = 5'($urandom % 31); rd = 5'($urandom % 31);
    case (kind)
      0: exec(enc_r(rs, rt, rd, pick_fn($urandom)));
      1: exec(enc_i(OP_ADDI, rs, rt, 16'($urandom)));
      2, 3: begin
        k = $urandom % 512;
        if ($urandom % 2) begin rs = 5'd0;  imm = 16'(32'h800 + 4 * k); end
        else begin rs = 5'd31; imm = 16'(-(4 + 4 * k)); end
        exec(enc_i(kind == 2 ? OP_LW : OP_SW, rs, rt, imm));
      end
      4: begin
        if ($urandom % 4 == 0) rt = rs;
        t = $urandom % 480;
        imm = 16'(t - (mpc / 4 + 1));
        exec(enc_i(OP_BEQ, rs, rt, imm));
      end
      default: exec({OP_J, 26'($urandom % 480)});
    endcase
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) mem[i] = $urandom;
    for (int i = 0; i < 32; i++) mreg[i] = 32'd0;
    mpc = 32'd0;
    clr_ctl();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // reset state
    chk("R11 reset pc", pc, 32'd0);
    chk("R11 reset ir", {20'd0, opcode, funct}, 32'd0);
    chk("R11 reset operands", {31'd0, ops_equal}, 32'd1);
    addr_sel = 1; #1 chk("R11 reset res", mem_addr, 32'd0); addr_sel = 0;

    // directed corner cases
    exec(enc_i(OP_ADDI, 5'd0, 5'd31, 16'h1000));
    exec(enc_i(OP_ADDI, 5'd0, 5'd1, 16'hFFFC));            // R4 negative immediate
    exec(enc_i(OP_ADDI, 5'd1, 5'd0, 16'h0005));            // R9 write to r0
    exec(enc_r(5'd1, 5'd0, 5'd2, 6'h2A));                  // R6 signed less-than
    exec(enc_r(5'd1, 5'd31, 5'd3, 6'h2B));                 // R6 unsigned less-than
    exec(enc_r(5'd0, 5'd1, 5'd0, 6'h20));                  // R9 rd = 0
    exec(enc_i(OP_LW, 5'd31, 5'd4, 16'hFFFC));             // R7 load into rt
    exec(enc_i(OP_SW, 5'd0, 5'd1, 16'h0800));
    exec(enc_i(OP_LW, 5'd0, 5'd5, 16'h0800));
    exec(enc_i(OP_BEQ, 5'd0, 5'd0, 16'h0010));             // taken forward
    exec(enc_i(OP_BEQ, 5'd1, 5'd0, 16'h0010));             // not taken
    exec(enc_i(OP_BEQ, 5'd5, 5'd1, 16'hFFF0));             // taken backward
    exec({OP_J, 26'h40});
    hold_window();

    for (int n = 0; n < 400; n++) begin
      rand_instr();
      if (n == 200) hold_window();
    end

    // dump every register through the store path
    for (int r = 0; r < 32; r++) begin
      if (mpc >= CODE_LIMIT) exec({OP_J, 26'd0});
      exec(enc_i(OP_SW, 5'd0, 5'(r), 16'(32'h800 + 4 * r)));
      if (r == 0) chk("R9 r0 reads zero", mem[512], 32'd0);
      else        chk("R7 final register", mem[512 + r], mreg[r]);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule